// File: doc/BRIEF.md
# Credit-Counted Flit Link

This block carries flits over one switch-to-switch hop without loss. A sending half keeps a count of the free slots in the buffer at the far end of the link. It takes a flit from its upstream port only while that count is above zero, and it spends one credit for each flit it launches. The receiving half queues arriving flits in a small FIFO and presents the oldest one on a downstream pop port. For every cycle in which flits leave the FIFO, it sends the number removed back over a multi-bit credit-return wire, one cycle later.

The sender adds the returned value to its count. A launch and a return can land in the same cycle, and the sender then applies both at once. The link register, the FIFO and the credit-return register are the only storage between the two halves, so the free-slot count is always exact. The upstream side sees a plain valid/ready pair. The downstream side sees valid/data with a pop strobe. The present credit count is brought out as a port.

Top module: `flit_credit_link`

## Requirements
- R1: Flits leave on `out_data` in the order they were accepted, each exactly once. While `out_valid` is high, `out_data` is the oldest flit not yet popped.
- R2: After reset, `avail_credits` equals DEPTH (4 by default), `in_ready` is 1 and `out_valid` is 0.
- R3: A flit is accepted at an edge where `in_valid` and `in_ready` are both 1. With no credit returning, this lowers `avail_credits` by exactly one at that edge.
- R4: `in_ready` is 0 exactly when `avail_credits` is 0. While it is 0, `in_valid` has no effect and no flit is taken.
- R5: A pop at edge t (`out_pop` with `out_valid` high) puts a return value of 1 on the 3-bit credit-return field after edge t. That value is added to `avail_credits` at edge t+1. A return value of 0 means no return.
- R6: At an edge with both an accepted flit and a nonzero return, the new count is the old count minus one plus the returned value.
- R7: A flit accepted at edge t into an empty receiver shows on `out_valid`/`out_data` after edge t+1.
- R8: No flit ever arrives at the receiver while its FIFO holds DEPTH flits.
- R9: `avail_credits` never exceeds DEPTH. Credits, flits in flight, queued flits and pending returns always sum to DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream flit present |
| in_data | input | DW | Upstream flit payload |
| in_ready | output | 1 | Sender holds at least one credit |
| avail_credits | output | clog2(DEPTH+1) | Present credit count |
| out_valid | output | 1 | Receiver FIFO is not empty |
| out_data | output | DW | Oldest queued flit |
| out_pop | input | 1 | Remove the oldest flit (ignored when empty) |

## Verification
The checker assumes that `out_pop` matters only while `out_valid` is high and that the returned value never exceeds DEPTH. The receiver produces both of these itself, so no outside constraint is needed. The slot-conservation and no-overflow properties assume that reset has been applied before the first flit. The bench holds reset for several cycles before it drives anything. The stimulus covers filling the link to zero credits, single returns, steady send-and-pop, and random valid/pop patterns. It never presents a pop to an empty queue as anything more than an ignored input.

// File: rtl/fcl_pkg.sv
package fcl_pkg;
  parameter int FCL_DEPTH = 4;   // receiver slots
  parameter int FCL_DW    = 32;  // flit width
  parameter int FCL_CRW   = 3;   // credit-return field width

  function automatic int unsigned fcl_cntw(input int unsigned depth);
    return $clog2(depth + 1);
  endfunction
endpackage

// File: rtl/fcl_tx.sv
module fcl_tx
  import fcl_pkg::*;
#(
  parameter int DW    = FCL_DW,
  parameter int DEPTH = FCL_DEPTH,
  parameter int CRW   = FCL_CRW,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [DW-1:0]   in_data,
  output logic            in_ready,
  output logic [CNTW-1:0] credits,
  output logic            lnk_valid,
  output logic [DW-1:0]   lnk_data,
  input  logic [CRW-1:0]  crd_ret
);
  localparam int SW = (CNTW > CRW ? CNTW : CRW) + 1;

  logic          send;
  logic [SW-1:0] sum;

  assign send = in_valid & in_ready;

  // spend and refill folded into one adder
  always_comb begin
    sum = SW'(credits) - SW'(send) + SW'(crd_ret);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      credits   <= CNTW'(DEPTH);
      in_ready  <= 1'b1;
      lnk_valid <= 1'b0;
    end else begin
      credits   <= CNTW'(sum);
      in_ready  <= (sum != '0);
      lnk_valid <= send;
    end
  end

  always_ff @(posedge clk) begin
    if (send) lnk_data <= in_data;
  end
endmodule

// File: rtl/fcl_rx.sv
module fcl_rx
  import fcl_pkg::*;
#(
  parameter int DW    = FCL_DW,
  parameter int DEPTH = FCL_DEPTH,
  parameter int CRW   = FCL_CRW,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCW  = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           lnk_valid,
  input  logic [DW-1:0]  lnk_data,
  output logic [CRW-1:0] crd_ret,
  output logic           out_valid,
  output logic [DW-1:0]  out_data,
  input  logic           out_pop,
  output logic [OCW-1:0] occ
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          pop;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign out_valid = (occ != '0);
  assign pop       = out_pop & out_valid;
  assign out_data  = mem[rd_ptr];

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (lnk_valid) mem[wr_ptr] <= lnk_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      occ     <= '0;
      crd_ret <= '0;
    end else begin
      if (lnk_valid) wr_ptr <= bump(wr_ptr);
      if (pop)       rd_ptr <= bump(rd_ptr);
      occ     <= occ + OCW'(lnk_valid) - OCW'(pop);
      // pops of this cycle go back as one field next cycle
      crd_ret <= CRW'(pop);
    end
  end
endmodule

// File: rtl/flit_credit_link.sv
module flit_credit_link
  import fcl_pkg::*;
#(
  parameter int DW    = FCL_DW,
  parameter int DEPTH = FCL_DEPTH,
  parameter int CRW   = FCL_CRW
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [DW-1:0]                in_data,
  output logic                         in_ready,
  output logic [$clog2(DEPTH+1)-1:0]   avail_credits,
  output logic                         out_valid,
  output logic [DW-1:0]                out_data,
  input  logic                         out_pop
);
  localparam int CNTW = $clog2(DEPTH + 1);

  logic            lnk_valid;
  logic [DW-1:0]   lnk_data;
  logic [CRW-1:0]  crd_ret;
  logic [CNTW-1:0] rx_occ;

  fcl_tx #(.DW(DW), .DEPTH(DEPTH), .CRW(CRW)) tx_i (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .credits(avail_credits),
    .lnk_valid(lnk_valid), .lnk_data(lnk_data), .crd_ret(crd_ret)
  );

  fcl_rx #(.DW(DW), .DEPTH(DEPTH), .CRW(CRW)) rx_i (
    .clk(clk), .rst(rst),
    .lnk_valid(lnk_valid), .lnk_data(lnk_data), .crd_ret(crd_ret),
    .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop),
    .occ(rx_occ)
  );
endmodule

// File: rtl/fcl_checker.sv
module fcl_checker #(
  parameter int DEPTH = 4,
  parameter int CRW   = 3,
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            in_ready,
  input logic [CNTW-1:0] avail_credits,
  input logic            lnk_valid,
  input logic [CRW-1:0]  crd_ret,
  input logic [CNTW-1:0] rx_occ
);
  int unsigned slots;
  assign slots = int'(avail_credits) + int'(lnk_valid) + int'(rx_occ) + int'(crd_ret);

  a_r2_reset_load: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (int'(avail_credits) == DEPTH));

  a_r3_spend: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && crd_ret == '0) |=>
      (int'(avail_credits) == int'($past(avail_credits)) - 1));

  a_r4_ready_tracks: assert property (@(posedge clk) disable iff (rst)
    in_ready == (avail_credits != '0));

  a_r6_send_and_return: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && crd_ret != '0) |=>
      (int'(avail_credits) == int'($past(avail_credits)) - 1 + int'($past(crd_ret))));

  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    lnk_valid |-> (int'(rx_occ) < DEPTH));

  a_r9_conserve: assert property (@(posedge clk) disable iff (rst)
    slots == DEPTH);

  a_r9_ceiling: assert property (@(posedge clk) disable iff (rst)
    int'(avail_credits) <= DEPTH);
endmodule

bind flit_credit_link fcl_checker #(.DEPTH(DEPTH), .CRW(CRW)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .avail_credits(avail_credits), .lnk_valid(lnk_valid),
  .crd_ret(crd_ret), .rx_occ(rx_occ)
);

// File: tb/flit_credit_link_tb_top.sv
module flit_credit_link_tb_top;
  localparam int DW    = 32;
  localparam int DEPTH = 4;
  localparam int CNTW  = $clog2(DEPTH + 1);

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic [DW-1:0]   in_data = '0;
  logic            in_ready;
  logic [CNTW-1:0] avail_credits;
  logic            out_valid;
  logic [DW-1:0]   out_data;
  logic            out_pop = 1'b0;

  always #4 clk = ~clk;

  flit_credit_link #(.DW(DW), .DEPTH(DEPTH), .CRW(3)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .avail_credits(avail_credits),
    .out_valid(out_valid), .out_data(out_data), .out_pop(out_pop)
  );

  int errors = 0;
  int checks = 0;

  // behavioural reference
  int          m_cred = DEPTH;
  int          m_ret  = 0;
  bit          m_lv   = 0;
  int          m_ld   = 0;
  int          m_q[$];
  int          seq    = 1;
  int          n_acc  = 0;
  string       m_tag  = "R9";

  always @(posedge clk) begin
    bit snd, pp;
    if (rst) begin
      m_cred = DEPTH; m_ret = 0; m_lv = 0; m_q.delete(); m_tag = "R9";
    end else begin
      snd = in_valid && (m_cred > 0);
      pp  = out_pop && (m_q.size() > 0);
      if (pp) void'(m_q.pop_front());
      if (m_lv) m_q.push_back(m_ld);
      m_tag  = (snd && m_ret > 0) ? "R6" : (m_ret > 0) ? "R5" : snd ? "R3" : "R9";
      m_cred = m_cred - int'(snd) + m_ret;
      m_ret  = int'(pp);
      m_lv   = snd;
      m_ld   = int'(in_data);
      if (snd) begin seq++; n_acc++; end
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(in_ready == (m_cred != 0), "R4", "in_ready", in_ready, m_cred != 0);
    chk(int'(avail_credits) == m_cred, m_tag, "credits", avail_credits, m_cred);
    chk(out_valid == (m_q.size() > 0), "R7", "out_valid", out_valid, m_q.size() > 0);
    if (m_q.size() > 0)
      chk(int'(out_data) == m_q[0], "R1", "out_data", out_data, m_q[0]);
  endtask

  // one cycle: check at the falling edge, then drive the next inputs
  task automatic step(input bit v, input bit p);
    @(negedge clk);
    compare_all();
    in_valid = v;
    out_pop  = p;
    in_data  = DW'(seq);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R2: values right after reset
    chk(int'(avail_credits) == DEPTH, "R2", "reset credits", avail_credits, DEPTH);
    chk(in_ready == 1'b1, "R2", "reset in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R2", "reset out_valid", out_valid, 0);

    // fill with no pops: credits drain to zero and sending stalls (R4, R8)
    repeat (8) step(1'b1, 1'b0);
    @(negedge clk);
    chk(avail_credits == '0, "R4", "stalled credits", avail_credits, 0);
    chk(in_ready == 1'b0, "R4", "stalled ready", in_ready, 0);
    chk(n_acc == DEPTH, "R8", "flits taken into full buffer", n_acc, DEPTH);
    in_valid = 1'b0;

    // a single pop returns one credit (R5)
    step(1'b0, 1'b1);
    repeat (4) step(1'b0, 1'b0);
    // steady send with pop: send and return together (R6)
    repeat (20) step(1'b1, 1'b1);
    // drain, then single-flit latency into empty receiver (R7)
    repeat (10) step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    repeat (4) step(1'b0, 1'b0);
    // mixed traffic
    for (int i = 0; i < 3000; i++)
      step(1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0));
    repeat (10) step(1'b0, 1'b1);
    @(negedge clk);
    compare_all();
    chk(int'(avail_credits) == DEPTH, "R9", "credits after drain", avail_credits, DEPTH);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule